// File: doc/BRIEF.md
# Serial Flash Write-Permission Front End

This block is the command front end of a serial flash device that answers as an SPI slave. While chip select is held low it shifts in bits from the data input on each rising edge of the serial clock, most significant bit first. It holds the state that decides whether writes may proceed: a write-enable latch, an auto-increment flag and a one-shot arm for the status-register write. The serial pins are brought into the system clock domain through a small synchronizer. Commands are decided only when chip select returns high, and only if the frame had the exact length its command needs.

The outputs are the write-enable latch, the auto-increment flag, a single-cycle grant pulse that allows a status-register write, and the serial output enable. The output enable stays low, because none of these commands returns data. The memory array, program and erase timing, address handling and the status register contents are handled elsewhere.

Top module: `wel_ctrl`

## Requirements
- R1: After a synchronous active-low reset, the write-enable latch, the auto-increment flag and the status-write arm are 0, and no grant is issued.
- R2: An 8-bit frame with code 0x06 sets the write-enable latch. The latch does not change while chip select is still low after the eighth bit; it changes only after chip select rises.
- R3: An 8-bit frame with code 0x04 clears both the write-enable latch and the auto-increment flag.
- R4: An 8-bit frame with code 0x50 sets the status-write arm. A 16-bit frame with code 0x01 in its first byte and any data byte in its second then gives exactly one grant pulse, one clock cycle wide, and clears the arm.
- R5: A 16-bit 0x01 frame gives no grant unless the arm was set by the last frame that was accepted. Any other accepted frame clears the arm. A second 0x01 frame in a row gives no grant.
- R6: A frame whose bit count is not exactly 8, or exactly 16 for code 0x01, is ignored. This covers a 0x01 frame of 8 bits and frames of 0 to 17 bits. The latch, the flag and the arm keep their values.
- R7: An 8-bit frame with any other code clears the arm and leaves the write-enable latch and the auto-increment flag unchanged.
- R8: An 8-bit frame with code 0xAF sets the auto-increment flag only if the write-enable latch is 1.
- R9: Frames are decoded the same way whether the serial clock idles low (mode 0) or high (mode 3).
- R10: The serial output enable stays 0 at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sck | input | 1 | Serial clock from the host, asynchronous to clk |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_mosi | input | 1 | Serial data input, MSB first |
| wel | output | 1 | Write-enable latch |
| aai | output | 1 | Auto-address-increment flag |
| sr_wr_grant | output | 1 | One-cycle pulse allowing a status-register write |
| miso_oe | output | 1 | Serial output driver enable (always 0 here) |

## Verification
Hidden state shows at the ports only through later commands. The arm has no output of its own. A wrong arm therefore first appears as a missing or extra grant on the next 16-bit 0x01 frame. A wrong bit count or a wrong shift order appears as a latch that moves after a frame that should be ignored, or that stays put after a valid one. Either shows a few clock cycles after chip select rises. The bench probes the arm this way after every one of the 256 command codes, in a fixed sequence. It also sweeps the frame length and repeats a sequence in both clock modes.

// File: rtl/wel_pkg.sv
// Package wel_pkg: command codes and frame sizing shared by the
// write-permission front end. Assumes byte-wide command codes.
package wel_pkg;
    localparam int          FRAME_MAX = 16;
    localparam int          CNT_W     = $clog2(FRAME_MAX + 2) + 1;
    localparam logic [7:0]  CMD_SET_WE   = 8'h06;
    localparam logic [7:0]  CMD_CLR_WE   = 8'h04;
    localparam logic [7:0]  CMD_ARM_SR   = 8'h50;
    localparam logic [7:0]  CMD_WR_SR    = 8'h01;
    localparam logic [7:0]  CMD_AUTO_INC = 8'hAF;

    typedef struct packed {
        logic [CNT_W-1:0]     nbits;
        logic [FRAME_MAX-1:0] bits;
    } frame_t;
endpackage

// File: rtl/wel_sync.sv
// Module wel_sync: multi-stage synchronizer for W independent bits.
// Assumes each input level is held for at least one clk period longer
// than STAGES so that no edge is lost. All bits see equal latency.
module wel_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] rst_val,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            // shift one synchronizer stage
            always_ff @(posedge clk) begin
                if (!rst_n) chain[s] <= rst_val;
                else if (s == 0) chain[s] <= d;
                else chain[s] <= chain[(s > 0) ? s - 1 : 0];
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/wel_shift.sv
// Module wel_shift: counts and shifts serial bits while chip select is
// low, and hands the finished frame over on the rising edge of chip
// select. Assumes synchronized inputs. The count saturates, so an
// overlong frame never reads as a valid length.
module wel_shift
    import wel_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   sck_s,
    input  logic   cs_n_s,
    input  logic   mosi_s,
    output logic   frm_vld,
    output frame_t frm
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic                 sck_q;
    logic                 cs_q;
    logic [CNT_W-1:0]     cnt;
    logic [FRAME_MAX-1:0] shreg;
    logic                 sck_rise;
    logic                 cs_rise;

    assign sck_rise = sck_s & ~sck_q;
    assign cs_rise  = cs_n_s & ~cs_q;

    // remember previous levels for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_q <= 1'b0;
            cs_q  <= 1'b1;
        end else begin
            sck_q <= sck_s;
            cs_q  <= cs_n_s;
        end
    end

    // shift data in on sck rising edges inside a selected frame
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            shreg <= '0;
        end else if (cs_n_s) begin
            cnt   <= '0;
        end else if (sck_rise) begin
            shreg <= {shreg[FRAME_MAX-2:0], mosi_s};
            cnt   <= (cnt == CNT_MAX) ? cnt : cnt + 1'b1;
        end
    end

    // present the completed frame for one cycle on chip-select rise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frm_vld <= 1'b0;
            frm     <= '0;
        end else begin
            frm_vld <= cs_rise;
            if (cs_rise) begin
                frm.nbits <= cnt;
                frm.bits  <= shreg;
            end
        end
    end

    AST_CNT_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n_s && cs_q) |-> (cnt == '0)); // R6
    AST_FRAME_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        frm_vld |=> !frm_vld); // R2
endmodule

// File: rtl/wel_decode.sv
// Module wel_decode: holds the write-enable latch, the auto-increment
// flag and the one-shot status-write arm, and applies one finished frame
// at a time. Frames of the wrong length leave all state alone.
module wel_decode
    import wel_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   frm_vld,
    input  frame_t frm,
    output logic   wel,
    output logic   aai,
    output logic   sr_wr_grant,
    output logic   miso_oe
);
    logic       arm;
    logic       len8;
    logic       len16;
    logic [7:0] code8;
    logic [7:0] code16;
    logic       wel_n, aai_n, arm_n, grant_n;

    assign len8   = (frm.nbits == 8);
    assign len16  = (frm.nbits == 16);
    assign code8  = frm.bits[7:0];
    assign code16 = frm.bits[15:8];

    // work out the next state from the frame just completed
    always_comb begin
        wel_n   = wel;
        aai_n   = aai;
        arm_n   = arm;
        grant_n = 1'b0;
        if (frm_vld) begin
            if (len16 && code16 == CMD_WR_SR) begin
                grant_n = arm;
                arm_n   = 1'b0;
            end else if (len8) begin
                arm_n = 1'b0;
                case (code8)
                    CMD_SET_WE:   wel_n = 1'b1;
                    CMD_CLR_WE:   begin wel_n = 1'b0; aai_n = 1'b0; end
                    CMD_ARM_SR:   arm_n = 1'b1;
                    CMD_AUTO_INC: aai_n = aai | wel;
                    CMD_WR_SR:    arm_n = arm;
                    default:      ;
                endcase
            end
        end
    end

    // register the permission state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wel         <= 1'b0;
            aai         <= 1'b0;
            arm         <= 1'b0;
            sr_wr_grant <= 1'b0;
        end else begin
            wel         <= wel_n;
            aai         <= aai_n;
            arm         <= arm_n;
            sr_wr_grant <= grant_n;
        end
    end

    assign miso_oe = 1'b0;

    AST_WEL_ON_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        (wel != $past(wel)) |-> $past(frm_vld)); // R2
    AST_GRANT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        sr_wr_grant |=> !sr_wr_grant); // R4
    AST_GRANT_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        sr_wr_grant |-> ($past(arm) && !arm)); // R5
    AST_CLR_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        $past(frm_vld && len8 && code8 == CMD_CLR_WE) |-> (!wel && !aai)); // R3
    AST_AAI_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(aai) |-> $past(wel)); // R8
endmodule

// File: rtl/wel_ctrl.sv
// Module wel_ctrl: top of the serial flash write-permission front end.
// Synchronizes the SPI pins into clk, frames the bits and decodes them.
// Assumes each sck phase lasts longer than SYNC_STAGES + 1 clk periods.
module wel_ctrl #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic spi_sck,
    input  logic spi_cs_n,
    input  logic spi_mosi,
    output logic wel,
    output logic aai,
    output logic sr_wr_grant,
    output logic miso_oe
);
    import wel_pkg::*;

    logic [2:0] pins_s;
    frame_t     frm;
    logic       frm_vld;

    wel_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .rst_val (3'b010),
        .d       ({spi_sck, spi_cs_n, spi_mosi}),
        .q       (pins_s)
    );

    wel_shift u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .sck_s   (pins_s[2]),
        .cs_n_s  (pins_s[1]),
        .mosi_s  (pins_s[0]),
        .frm_vld (frm_vld),
        .frm     (frm)
    );

    wel_decode u_decode (
        .clk         (clk),
        .rst_n       (rst_n),
        .frm_vld     (frm_vld),
        .frm         (frm),
        .wel         (wel),
        .aai         (aai),
        .sr_wr_grant (sr_wr_grant),
        .miso_oe     (miso_oe)
    );

    AST_OE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        sr_wr_grant |-> !miso_oe); // R10
endmodule

// File: tb/wel_ctrl_bench.sv
module wel_ctrl_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0;
    logic cs_n = 1'b1;
    logic mosi = 1'b0;
    logic wel, aai, grant, oe;
    int   checks = 0;
    int   fails = 0;
    int   gcnt = 0;
    int   oe_seen = 0;
    logic mode3 = 1'b0;

    always #5 clk = ~clk;

    wel_ctrl u_wel_ctrl (
        .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n),
        .spi_mosi(mosi), .wel(wel), .aai(aai), .sr_wr_grant(grant),
        .miso_oe(oe)
    );

    // count grant pulses and any output-enable activity
    always @(posedge clk) begin
        if (grant) gcnt++;
        if (oe) oe_seen++;
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic waitc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // shift n bits MSB first, leave cs low
    task automatic shift_bits(input logic [17:0] v, input int n);
        sck = mode3;
        waitc(4);
        cs_n = 1'b0;
        waitc(4);
        for (int i = n - 1; i >= 0; i--) begin
            if (mode3) sck = 1'b0;
            mosi = v[i];
            waitc(4);
            sck = 1'b1;
            waitc(4);
            if (!mode3) sck = 1'b0;
        end
        waitc(4);
    endtask

    task automatic frame(input logic [17:0] v, input int n);
        shift_bits(v, n);
        cs_n = 1'b1;
        waitc(10);
    endtask

    task automatic cmd(input logic [7:0] c);
        frame({10'd0, c}, 8);
    endtask

    task automatic wrsr(input logic [7:0] d);
        frame({2'b00, 8'h01, d}, 16);
    endtask

    initial begin
        int g0;
        waitc(6);
        rst_n = 1'b1;
        waitc(4);
        // R1 reset state
        chk("R1 wel", wel, 0);
        chk("R1 aai", aai, 0);
        g0 = gcnt; wrsr(8'h5A);
        chk("R1 arm clear after reset", gcnt - g0, 0);

        // R2 latch not set before cs rises
        shift_bits(18'h06, 8);
        chk("R2 wel before cs rise", wel, 0);
        cs_n = 1'b1; waitc(10);
        chk("R2 wel after cs rise", wel, 1);

        // R8 aai needs wel; R3 clear both
        cmd(8'hAF);
        chk("R8 aai set with wel", aai, 1);
        cmd(8'h04);
        chk("R3 wel cleared", wel, 0);
        chk("R3 aai cleared", aai, 0);
        cmd(8'hAF);
        chk("R8 aai not set without wel", aai, 0);

        // R4 armed write, R5 second write not granted
        cmd(8'h50); g0 = gcnt; wrsr(8'hFF);
        chk("R4 grant count", gcnt - g0, 1);
        g0 = gcnt; wrsr(8'h00);
        chk("R5 repeat wrsr no grant", gcnt - g0, 0);
        cmd(8'h50); cmd(8'h06); g0 = gcnt; wrsr(8'h12);
        chk("R5 arm lost after other cmd", gcnt - g0, 0);
        cmd(8'h50); cmd(8'h3C); g0 = gcnt; wrsr(8'h12);
        chk("R7 unknown clears arm", gcnt - g0, 0);
        chk("R7 wel unchanged", wel, 1);

        // R6 ignored frame keeps arm
        cmd(8'h50); frame(18'h0C, 7); g0 = gcnt; wrsr(8'h34);
        chk("R6 arm kept over bad length", gcnt - g0, 1);

        // R6 length sweep with code 0x06 from wel=0
        for (int n = 0; n <= 17; n++) begin
            cmd(8'h04);
            frame(18'h06 << ((n > 8) ? n - 8 : 0) >> ((n < 8) ? 8 - n : 0), n);
            chk($sformatf("R6 len %0d wel", n), wel, (n == 8) ? 1 : 0);
        end

        // R7/R5/R6 sweep every code from known state
        for (int c = 0; c < 256; c++) begin
            cmd(8'h04); cmd(8'h06); cmd(8'h50);
            cmd(c[7:0]);
            chk($sformatf("R7 code %02x wel", c), wel, (c == 8'h04) ? 0 : 1);
            chk($sformatf("R8 code %02x aai", c), aai, (c == 8'hAF) ? 1 : 0);
            g0 = gcnt; wrsr(8'hA5);
            chk($sformatf("R5 code %02x grant", c), gcnt - g0,
                (c == 8'h50 || c == 8'h01) ? 1 : 0);
        end

        // R9 mode 3 repeats key sequence
        mode3 = 1'b1;
        cmd(8'h04);
        chk("R9 mode3 wel clear", wel, 0);
        cmd(8'h06);
        chk("R9 mode3 wel set", wel, 1);
        cmd(8'h50); g0 = gcnt; wrsr(8'h80);
        chk("R9 mode3 grant", gcnt - g0, 1);
        cmd(8'hAF);
        chk("R9 mode3 aai", aai, 1);

        chk("R10 output enable never high", oe_seen, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule